// File: doc/BRIEF.md
# Retransmitting Station Controller with Capped Exponential Backoff

This block governs the transmit side of one station on a shared medium. A start request launches a transmission; if the medium reports no collision, the transmission completes after a fixed packet time and the block raises a one-cycle end pulse and a sticky done flag. If a collision-detect pulse arrives while transmitting, the attempt is abandoned. The failure count goes up by one, and the station waits a random number of slots before it senses the medium again.

The random slot count is taken from a random word supplied on an input, masked to its k+1 low bits, where k is the failure count capped at BC_MAX. When the wait runs out, the station samples the busy input. A free medium triggers a resend. A busy medium causes a fresh draw at the same failure count. Retries never stop. All timing is counted in clock cycles: TX_TICKS cycles per packet (packet time plus propagation, 808 by default) and SLOT_TICKS cycles per slot (twice the propagation delay, 52 by default). All pins are plain control and status pins; there is no streamed data and so no back-pressure.

Top module: `backoff_station`

## Requirements
- R1: After reset, send_o, end_o and done_o are all 0 and the block is idle.
- R2: A start_i sampled while idle yields a one-cycle send_o pulse in the next cycle and clears done_o in that same cycle.
- R3: With no collision, end_o pulses for one cycle exactly TX_TICKS cycles after the send_o pulse, and done_o rises with it.
- R4: done_o stays 1 after a successful end until the next accepted start_i.
- R5: A cd_i sampled during a transmission cancels that attempt (no end_o), increments the failure count n, and the next send_o comes S*SLOT_TICKS+1 cycles after the cd_i edge, with S equal to rand_i sampled at that edge ANDed with 2^(k+1)-1.
- R6: k = min(n, BC_MAX); with BC_MAX=2 and rand_i all ones, the 1st collision gives S=3 and every later collision gives S=7.
- R7: S=0 makes the station sense the medium in the cycle right after the draw.
- R8: If busy_i is 1 at the sensing cycle, no send_o occurs and a new S is drawn from rand_i with the same n; when busy_i is 0 at a sensing cycle, send_o follows in the next cycle.
- R9: The number of retransmissions is unlimited; after any number of collisions the packet is still resent and can complete.
- R10: cd_i and busy_i have no effect while idle, and start_i has no effect while a packet is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to send a new packet |
| cd_i | input | 1 | Collision detected on the medium |
| busy_i | input | 1 | Medium sensed busy |
| rand_i | input | BC_MAX+1 | Random word used for the slot draw |
| send_o | output | 1 | One-cycle pulse: transmission begins |
| end_o | output | 1 | One-cycle pulse: transmission finished without collision |
| done_o | output | 1 | Packet delivered, held until next start |

## Verification
A wrong failure count or mask shows up at the first collision whose draw has high random bits. The resend then comes a multiple of SLOT_TICKS cycles early or late, and the gap between the cd_i edge and send_o reveals it within one backoff window. A stuck slot or packet timer shows as send_o or end_o off by one or more cycles relative to the computed gap. A lost state update shows as a missing, doubled or spurious pulse, or as done_o changing without a start. Each of these is visible within at most 7*SLOT_TICKS+TX_TICKS cycles of the offending event.

// File: rtl/bstn_pkg.sv
package bstn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TX    = 2'd1,
    ST_WAIT  = 2'd2,
    ST_SENSE = 2'd3
  } bstn_state_e;
endpackage

// File: rtl/bstn_fail_ctr.sv
module bstn_fail_ctr #(
  parameter int N_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           inc_i,
  output logic [N_W-1:0] n_o,
  output logic [N_W-1:0] n_plus_o
);
  localparam logic [N_W-1:0] N_MAX = '1;

  assign n_plus_o = (n_o == N_MAX) ? N_MAX : n_o + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)     n_o <= '0;
    else if (clr_i) n_o <= '0;
    else if (inc_i) n_o <= n_plus_o;
  end
endmodule

// File: rtl/bstn_slot_draw.sv
module bstn_slot_draw #(
  parameter int N_W    = 8,
  parameter int DRAW_W = 3
) (
  input  logic [N_W-1:0]    n_i,
  input  logic [DRAW_W-1:0] rand_i,
  output logic [DRAW_W-1:0] slots_o
);
  // bit i kept when i <= min(n, BC_MAX), i.e. when i <= n
  for (genvar i = 0; i < DRAW_W; i++) begin : g_mask
    assign slots_o[i] = rand_i[i] & (n_i >= N_W'(i));
  end
endmodule

// File: rtl/bstn_slot_timer.sv
module bstn_slot_timer #(
  parameter int SLOT_TICKS = 52,
  parameter int DRAW_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DRAW_W-1:0] slots_i,
  output logic              expire_o
);
  localparam int SLOT_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [SLOT_W-1:0] TICK_LAST = SLOT_W'(SLOT_TICKS - 1);

  logic [SLOT_W-1:0] tick_q;
  logic [DRAW_W-1:0] left_q;
  logic              run_q;

  assign expire_o = run_q && (tick_q == '0) && (left_q == DRAW_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      tick_q <= '0;
      left_q <= '0;
    end else if (load_i) begin
      run_q  <= 1'b1;
      tick_q <= TICK_LAST;
      left_q <= slots_i;
    end else if (run_q) begin
      if (tick_q != '0) begin
        tick_q <= tick_q - 1'b1;
      end else if (left_q == DRAW_W'(1)) begin
        run_q <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
        tick_q <= TICK_LAST;
      end
    end
  end
endmodule

// File: rtl/backoff_station.sv
module backoff_station
  import bstn_pkg::*;
#(
  parameter int TX_TICKS   = 808,
  parameter int SLOT_TICKS = 52,
  parameter int BC_MAX     = 2,
  parameter int N_W        = 8,
  localparam int DRAW_W    = BC_MAX + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cd_i,
  input  logic              busy_i,
  input  logic [DRAW_W-1:0] rand_i,
  output logic              send_o,
  output logic              end_o,
  output logic              done_o
);
  localparam int TX_W = (TX_TICKS > 1) ? $clog2(TX_TICKS) : 1;
  localparam logic [TX_W-1:0] TX_LAST = TX_W'(TX_TICKS - 1);

  bstn_state_e       st_q;
  logic [TX_W-1:0]   tx_cnt_q;
  logic [N_W-1:0]    n_cur, n_plus, n_draw;
  logic [DRAW_W-1:0] slots;
  logic              fail_inc, fail_clr, redraw, tmr_load, expire;

  assign fail_clr = (st_q == ST_IDLE) && start_i;
  assign fail_inc = (st_q == ST_TX) && cd_i;
  assign redraw   = (st_q == ST_SENSE) && busy_i;
  assign n_draw   = (st_q == ST_TX) ? n_plus : n_cur;
  assign tmr_load = (fail_inc || redraw) && (slots != '0);

  bstn_fail_ctr #(.N_W(N_W)) u_fail (
    .clk(clk), .rst_n(rst_n), .clr_i(fail_clr), .inc_i(fail_inc),
    .n_o(n_cur), .n_plus_o(n_plus)
  );

  bstn_slot_draw #(.N_W(N_W), .DRAW_W(DRAW_W)) u_draw (
    .n_i(n_draw), .rand_i(rand_i), .slots_o(slots)
  );

  bstn_slot_timer #(.SLOT_TICKS(SLOT_TICKS), .DRAW_W(DRAW_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .slots_i(slots),
    .expire_o(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      tx_cnt_q <= '0;
      send_o   <= 1'b0;
      end_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      send_o <= 1'b0;
      end_o  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q     <= ST_TX;
            tx_cnt_q <= TX_LAST;
            send_o   <= 1'b1;
            done_o   <= 1'b0;
          end
        end
        ST_TX: begin
          if (cd_i) begin
            st_q <= (slots == '0) ? ST_SENSE : ST_WAIT;
          end else if (tx_cnt_q == '0) begin
            st_q   <= ST_IDLE;
            end_o  <= 1'b1;
            done_o <= 1'b1;
          end else begin
            tx_cnt_q <= tx_cnt_q - 1'b1;
          end
        end
        ST_WAIT: begin
          if (expire) st_q <= ST_SENSE;
        end
        ST_SENSE: begin
          if (busy_i) begin
            st_q <= (slots == '0) ? ST_SENSE : ST_WAIT;
          end else begin
            st_q     <= ST_TX;
            tx_cnt_q <= TX_LAST;
            send_o   <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bstn_chk.sv
module bstn_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic send_o,
  input logic end_o,
  input logic done_o
);
  assert_send_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    send_o |=> !send_o);

  assert_end_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> !end_o);

  assert_no_send_with_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(send_o && end_o));

  assert_done_rise_on_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> end_o);

  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  assert_done_clear_on_send_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_o) |-> send_o);
endmodule

bind backoff_station bstn_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .send_o(send_o), .end_o(end_o), .done_o(done_o)
);

// File: tb/sim_backoff_station.sv
module sim_backoff_station;
  localparam int TXT  = 808;
  localparam int SLT  = 52;
  localparam int BCM  = 2;
  localparam int DW   = BCM + 1;
  localparam int WDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, cd_i = 1'b0, busy_i = 1'b0;
  logic [DW-1:0] rand_i = '0;
  logic send_o, end_o, done_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  backoff_station #(.TX_TICKS(TXT), .SLOT_TICKS(SLT), .BC_MAX(BCM), .N_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cd_i(cd_i), .busy_i(busy_i),
    .rand_i(rand_i), .send_o(send_o), .end_o(end_o), .done_o(done_o)
  );

  function automatic int exp_slots(int n, int r);
    int k = (n < BCM) ? n : BCM;
    return r & ((1 << (k + 1)) - 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts negedges until send_o; flags any end_o seen meanwhile
  task automatic wait_send(output int gap, output int saw_end);
    gap = 0; saw_end = 0;
    do begin
      @(negedge clk);
      start_i = 1'b0; cd_i = 1'b0;
      gap++;
      if (end_o) saw_end = 1;
    end while (!send_o && gap < 4000);
  endtask

  task automatic wait_end(output int gap, output int saw_send);
    gap = 0; saw_send = 0;
    do begin
      @(negedge clk);
      start_i = 1'b0;
      gap++;
      if (send_o) saw_send = 1;
    end while (!end_o && gap < 4000);
  endtask

  task automatic launch(string req);
    int g, e;
    start_i = 1'b1;
    wait_send(g, e);
    chk(req, g, 1);
    chk(req, done_o, 0);
  endtask

  // collision number nth after delay d in transmission, random r
  task automatic collide(string req, int nth, int d, int r);
    int g, e;
    repeat (d) @(negedge clk);
    cd_i = 1'b1; rand_i = DW'(r);
    wait_send(g, e);
    chk(req, g, exp_slots(nth, r) * SLT + 2);
    chk({req, " no end"}, e, 0);
  endtask

  task automatic finish_pkt(string req, int skip);
    int g, s;
    wait_end(g, s);
    chk(req, g, TXT - skip);
    chk({req, " no send"}, s, 0);
    chk({req, " done"}, done_o, 1);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int g, s, ncol;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 send", send_o, 0); chk("R1 end", end_o, 0); chk("R1 done", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle no send", send_o, 0);

    // R2/R3 clean packet
    launch("R2");
    finish_pkt("R3", 0);

    // R4/R10 idle: cd and busy ignored, done held
    cd_i = 1'b1; busy_i = 1'b1; s = 0;
    repeat (20) begin @(negedge clk); if (send_o) s = 1; end
    cd_i = 1'b0; busy_i = 1'b0;
    chk("R10 idle send", s, 0);
    chk("R4 done held", done_o, 1);

    // R10 start ignored mid-packet
    launch("R2 second");
    repeat (5) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    finish_pkt("R10 start ignored", 6);

    // R6 cap: all-ones random
    launch("R6 launch");
    collide("R6 n1", 1, 3, 7);
    collide("R6 n2", 2, 10, 7);
    collide("R6 n3", 3, 0, 7);
    collide("R6 n4", 4, 100, 7);
    finish_pkt("R6 end", 0);

    // R7 zero slots, R8 busy redraw with same n
    launch("R7 launch");
    repeat (4) @(negedge clk);
    cd_i = 1'b1; rand_i = '0; busy_i = 1'b1;
    @(negedge clk);
    cd_i = 1'b0; rand_i = '1;
    chk("R7 no send", send_o, 0);
    @(negedge clk);
    busy_i = 1'b0;
    chk("R8 no send busy", send_o, 0);
    g = 1;
    do begin @(negedge clk); g++; end while (!send_o && g < 4000);
    chk("R8 redraw n1 gap", g, 3 * SLT + 2);
    finish_pkt("R8 end", 0);

    // R7/R8 busy with zero draw senses every cycle
    launch("R8 launch");
    repeat (2) @(negedge clk);
    cd_i = 1'b1; rand_i = '0; busy_i = 1'b1;
    @(negedge clk);
    cd_i = 1'b0; s = 0;
    repeat (30) begin @(negedge clk); if (send_o) s = 1; end
    chk("R8 held busy", s, 0);
    busy_i = 1'b0;
    @(negedge clk);
    chk("R7 immediate send", send_o, 1);
    finish_pkt("R7 end", 0);

    // R9 many retries
    launch("R9 launch");
    for (int i = 1; i <= 12; i++) collide("R9 retry", i, 1, 0);
    collide("R9 retry last", 13, 7, 5);
    finish_pkt("R9 end", 0);

    // R5 random mix
    for (int p = 0; p < 25; p++) begin
      launch("R5 launch");
      ncol = $urandom_range(0, 3);
      for (int c = 1; c <= ncol; c++)
        collide("R5 random", c, $urandom_range(0, TXT - 2), $urandom_range(0, 7));
      finish_pkt("R5 end", 0);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule